// File: doc/BRIEF.md
# Dual-Button Delayed Reset Controller

This block issues a system reset from two active-low push-buttons, but only after both buttons have been held down together, without a break, for a long setup delay. A short press of one or both buttons produces no reset. Because of this, the same buttons can also drive ordinary interrupt inputs elsewhere in the system. All delays are counted in periods of a shared timebase `tick` input, so a single parameter set covers both silicon timing and scaled-down benches. Every asynchronous input passes through a two-flop synchronizer before the state machine uses it.

Two release styles are chosen by parameter. In follow mode, the reset lasts only while both buttons stay down. In fixed mode, the reset is a pulse of a set length that ignores the buttons while it runs. If the buttons are still held when the pulse ends, the block waits for a release before it will arm again. A supply-good flag forces the output inactive and returns the state machine to its off state.

A latched test mode shortens the setup delay. An overvoltage flag on the primary button requests it. The flag must stay high for an initial qualification time. When that time is reached, the output gives a feedback reset: a fixed pulse in fixed mode, or a reset that lasts while the flag stays high in follow mode. The block then arms with the short delay until the next power cycle.

States, as named in the RTL:
- `ST_OFF`: the supply is low.
- `ST_IDLE`: waiting for input.
- `ST_ARM`: counting the setup delay.
- `ST_HOLD`: follow-mode reset.
- `ST_PULSE`: fixed-width reset.
- `ST_WAIT_REL`: waiting for a button to be released after a pulse.
- `ST_TEST_QUAL`: qualifying the overvoltage flag.
- `ST_TEST_ACK`: follow-mode feedback while the flag stays high.

Transitions:
- Any state → `ST_OFF` when the synced supply flag is low. This also clears test mode.
- `ST_OFF` → `ST_IDLE` when the supply flag is high.
- `ST_IDLE`/`ST_ARM` → `ST_TEST_QUAL` when the overvoltage flag is high and test mode is not yet set. This transition has priority over the buttons.
- `ST_IDLE` → `ST_ARM` when both buttons are down.
- `ST_ARM` → `ST_IDLE` when either button is released.
- `ST_ARM` → `ST_HOLD` or `ST_PULSE` when the delay count completes.
- `ST_HOLD`/`ST_WAIT_REL` → `ST_IDLE` when either button is released.
- `ST_PULSE` → `ST_WAIT_REL` when the pulse ends with both buttons still down; otherwise → `ST_IDLE`.
- `ST_TEST_QUAL` → `ST_IDLE` if the flag drops before the qualification count completes.
- `ST_TEST_QUAL` → `ST_PULSE` or `ST_TEST_ACK` when the qualification count completes. This transition sets test mode.
- `ST_TEST_ACK` → `ST_IDLE` when the flag drops.

Top module: `dbl_reset_ctrl`

## Requirements
- R1: With the supply good, the reset becomes active only after both synced buttons have been low through `SETUP_TICKS` ticks, counted from the cycle after both are seen low.
- R2: If either button goes high before the count completes, no reset is produced. The next joint press starts the count from zero.
- R3: In follow mode (`FIXED_PULSE`=0), the reset stays active while both buttons stay low. It goes inactive on the first synced cycle in which either button is high.
- R4: In fixed mode (`FIXED_PULSE`=1), the reset lasts until `PULSE_TICKS` ticks have been counted, whatever the buttons do during the pulse.
- R5: In fixed mode, if both buttons are still low when the pulse ends, no new count starts until at least one button has been released.
- R6: While the synced supply flag is low, the reset is inactive, including mid-pulse. The buttons and the overvoltage flag are ignored.
- R7: The overvoltage flag, held high through `TEST_INIT_TICKS` ticks, sets test mode and gives a feedback reset: a `PULSE_TICKS` pulse in fixed mode, or a reset that lasts while the flag stays high in follow mode. If the flag drops earlier, test mode is not set and no reset occurs.
- R8: In test mode, the setup delay is `TEST_SETUP_TICKS` instead of `SETUP_TICKS`.
- R9: Test mode persists through any button activity. It is cleared only by the supply flag going low; it is not set again when the supply returns.
- R10: With `ACTIVE_HIGH`=1, an active reset drives `reset_out` to 1. With `ACTIVE_HIGH`=0, it drives `reset_out` to 0. After `rst_n`, the output is at its inactive level.
- R11: Each of the four asynchronous inputs reaches the state machine through two flip-flops. A change applied before clock edge k can therefore alter the state at edge k+2 at the earliest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| btn_a_n | input | 1 | Primary push-button, active low |
| btn_b_n | input | 1 | Secondary push-button, active low |
| supply_ok | input | 1 | Supply-good flag from the analog monitor |
| ovp_a | input | 1 | Overvoltage-detected flag on the primary button |
| tick | input | 1 | Timebase strobe, one cycle wide |
| reset_out | output | 1 | Reset output, polarity set by `ACTIVE_HIGH` |

## Verification
The hardest case to reach is the test-mode path. It needs:
- a rejected short overvoltage request;
- a qualified request;
- a shortened arm that reaches the reset;
- a supply cycle, after which the same short hold must no longer reset.

The stimulus drives all of these in sequence, on a follow-mode instance and a fixed-mode instance side by side. A behavioural queue-and-counter model in the bench predicts the output of each instance on every clock. The fixed-mode path of holding the buttons past the end of the pulse, and of releasing them mid-pulse, is driven on purpose. So is a supply drop in the middle of an active reset.

// File: rtl/dbrst_pkg.sv
package dbrst_pkg;
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_ARM       = 3'd2,
        ST_HOLD      = 3'd3,
        ST_PULSE     = 3'd4,
        ST_WAIT_REL  = 3'd5,
        ST_TEST_QUAL = 3'd6,
        ST_TEST_ACK  = 3'd7
    } dbrst_state_e;
endpackage

// File: rtl/dbrst_sync.sv
module dbrst_sync #(
    parameter int             N       = 4,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d_async[i];
                stab_q <= meta_q;
            end
        end
        assign q_sync[i] = stab_q;
    end
endmodule

// File: rtl/dbrst_tick_timer.sv
module dbrst_tick_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] cnt,
    output logic          done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/dbl_reset_ctrl.sv
module dbl_reset_ctrl
    import dbrst_pkg::*;
#(
    parameter int SETUP_TICKS      = 4000,
    parameter int PULSE_TICKS      = 210,
    parameter int TEST_INIT_TICKS  = 42,
    parameter int TEST_SETUP_TICKS = 21,
    parameter bit FIXED_PULSE      = 1'b0,
    parameter bit ACTIVE_HIGH      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_a_n,
    input  logic btn_b_n,
    input  logic supply_ok,
    input  logic ovp_a,
    input  logic tick,
    output logic reset_out
);
    localparam int MAX_AB   = (SETUP_TICKS > PULSE_TICKS) ? SETUP_TICKS : PULSE_TICKS;
    localparam int MAX_CD   = (TEST_INIT_TICKS > TEST_SETUP_TICKS) ? TEST_INIT_TICKS : TEST_SETUP_TICKS;
    localparam int MAX_T    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW       = $clog2(MAX_T + 1);
    localparam int NSYNC    = 4;

    // synchronizers: bit0 btn_a_n, bit1 btn_b_n, bit2 supply_ok, bit3 ovp_a
    logic [NSYNC-1:0] raw_in, syn_in;
    assign raw_in = {ovp_a, supply_ok, btn_b_n, btn_a_n};

    dbrst_sync #(.N(NSYNC), .RST_VAL(4'b0011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    logic both_held, sup_s, ovp_s;
    assign both_held = ~syn_in[0] & ~syn_in[1];
    assign sup_s     = syn_in[2];
    assign ovp_s     = syn_in[3];

    dbrst_state_e state, state_nxt;
    logic         test_mode, test_nxt;
    logic [CW-1:0] limit, tmr_cnt;
    logic         tmr_run, tmr_clr, tmr_done;
    logic         out_active;

    always_comb begin
        tmr_run = (state == ST_ARM) || (state == ST_PULSE) || (state == ST_TEST_QUAL);
        unique case (state)
            ST_ARM:       limit = test_mode ? CW'(TEST_SETUP_TICKS) : CW'(SETUP_TICKS);
            ST_PULSE:     limit = CW'(PULSE_TICKS);
            ST_TEST_QUAL: limit = CW'(TEST_INIT_TICKS);
            default:      limit = CW'(1);
        endcase
    end

    assign tmr_clr = (state_nxt != state);

    dbrst_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .clr   (tmr_clr),
        .tick  (tick),
        .limit (limit),
        .cnt   (tmr_cnt),
        .done  (tmr_done)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        test_nxt  = test_mode;
        if (!sup_s) begin
            state_nxt = ST_OFF;
            test_nxt  = 1'b0;
        end else begin
            unique case (state)
                ST_OFF: state_nxt = ST_IDLE;
                ST_IDLE: begin
                    if (!test_mode && ovp_s)  state_nxt = ST_TEST_QUAL;
                    else if (both_held)       state_nxt = ST_ARM;
                end
                ST_ARM: begin
                    if (!test_mode && ovp_s)  state_nxt = ST_TEST_QUAL;
                    else if (!both_held)      state_nxt = ST_IDLE;
                    else if (tmr_done)        state_nxt = FIXED_PULSE ? ST_PULSE : ST_HOLD;
                end
                ST_HOLD: begin
                    if (!both_held)           state_nxt = ST_IDLE;
                end
                ST_PULSE: begin
                    if (tmr_done)             state_nxt = both_held ? ST_WAIT_REL : ST_IDLE;
                end
                ST_WAIT_REL: begin
                    if (!both_held)           state_nxt = ST_IDLE;
                end
                ST_TEST_QUAL: begin
                    if (!ovp_s) begin
                        state_nxt = ST_IDLE;
                    end else if (tmr_done) begin
                        test_nxt  = 1'b1;
                        state_nxt = FIXED_PULSE ? ST_PULSE : ST_TEST_ACK;
                    end
                end
                ST_TEST_ACK: begin
                    if (!ovp_s)               state_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            test_mode <= 1'b0;
        end else begin
            state     <= state_nxt;
            test_mode <= test_nxt;
        end
    end

    // output process
    always_comb begin
        out_active = sup_s && ((state == ST_HOLD) || (state == ST_PULSE) ||
                               (state == ST_TEST_ACK));
        reset_out  = ACTIVE_HIGH ? out_active : ~out_active;
    end

    // assertions
    AST_ARM_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |-> $past(both_held));                                  // R1
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !both_held) |=> (state != ST_HOLD));                 // R3
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (tmr_cnt < CW'(PULSE_TICKS)));                    // R4
    AST_SUPPLY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_s) |=> (state == ST_OFF && !test_mode));                            // R6
    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && sup_s) |=> test_mode);                                      // R9
    AST_ACK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEST_ACK) |-> $past(ovp_s));                                 // R7
endmodule

// File: tb/tb_dbl_reset_ctrl.sv
module tb_dbl_reset_ctrl;
    localparam int SETUP = 8;
    localparam int PULSE = 5;
    localparam int TINIT = 6;
    localparam int TSET  = 3;
    localparam int TDIV  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_a_n = 1'b1, btn_b_n = 1'b1, supply_ok = 1'b0, ovp_a = 1'b0, tick = 1'b0;
    logic out_follow, out_fixed;

    always #5 clk = ~clk;

    dbl_reset_ctrl #(.SETUP_TICKS(SETUP), .PULSE_TICKS(PULSE), .TEST_INIT_TICKS(TINIT),
        .TEST_SETUP_TICKS(TSET), .FIXED_PULSE(1'b0), .ACTIVE_HIGH(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .supply_ok(supply_ok), .ovp_a(ovp_a), .tick(tick), .reset_out(out_follow));

    dbl_reset_ctrl #(.SETUP_TICKS(SETUP), .PULSE_TICKS(PULSE), .TEST_INIT_TICKS(TINIT),
        .TEST_SETUP_TICKS(TSET), .FIXED_PULSE(1'b1), .ACTIVE_HIGH(1'b1)) dut_fx (
        .clk(clk), .rst_n(rst_n), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .supply_ok(supply_ok), .ovp_a(ovp_a), .tick(tick), .reset_out(out_fixed));

    // tick strobe
    int tdiv = 0;
    always @(negedge clk) begin
        tick = (tdiv == TDIV - 1);
        tdiv = (tdiv + 1) % TDIV;
    end

    // ---------------- behavioural reference model ----------------
    // phase codes: 0 off,1 idle,2 arming,3 follow-on,4 pulse,5 wait release,6 qualify,7 ack
    bit q_a[$], q_b[$], q_s[$], q_o[$];
    int phase [2];
    int elapsed [2];
    bit tmode [2];
    bit ea, eb, es, eo;

    function automatic void enter(int c, int p);
        phase[c] = p;
        elapsed[c] = 0;
    endfunction

    function automatic bit count_done(int c, int lim, bit tk);
        if (!tk) return 1'b0;
        if (elapsed[c] + 1 == lim) return 1'b1;
        elapsed[c]++;
        return 1'b0;
    endfunction

    function automatic void model_step(int c, bit tk);
        bit both = !ea && !eb;
        if (!es) begin
            phase[c] = 0; elapsed[c] = 0; tmode[c] = 1'b0;
            return;
        end
        case (phase[c])
            0: enter(c, 1);
            1: if (!tmode[c] && eo) enter(c, 6); else if (both) enter(c, 2);
            2: begin
                if (!tmode[c] && eo) enter(c, 6);
                else if (!both) enter(c, 1);
                else if (count_done(c, tmode[c] ? TSET : SETUP, tk)) enter(c, (c == 1) ? 4 : 3);
            end
            3: if (!both) enter(c, 1);
            4: if (count_done(c, PULSE, tk)) enter(c, both ? 5 : 1);
            5: if (!both) enter(c, 1);
            6: begin
                if (!eo) enter(c, 1);
                else if (count_done(c, TINIT, tk)) begin
                    tmode[c] = 1'b1;
                    enter(c, (c == 1) ? 4 : 7);
                end
            end
            7: if (!eo) enter(c, 1);
            default: enter(c, 0);
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_a = '{1'b1, 1'b1}; q_b = '{1'b1, 1'b1};
            q_s = '{1'b0, 1'b0}; q_o = '{1'b0, 1'b0};
            for (int c = 0; c < 2; c++) begin phase[c] = 0; elapsed[c] = 0; tmode[c] = 0; end
        end else begin
            ea = q_a[0]; eb = q_b[0]; es = q_s[0]; eo = q_o[0];
            for (int c = 0; c < 2; c++) model_step(c, tick);
            q_a.push_back(btn_a_n);   void'(q_a.pop_front());
            q_b.push_back(btn_b_n);   void'(q_b.pop_front());
            q_s.push_back(supply_ok); void'(q_s.pop_front());
            q_o.push_back(ovp_a);     void'(q_o.pop_front());
        end
    end

    function automatic bit model_active(int c);
        return q_s[0] && (phase[c] == 3 || phase[c] == 4 || phase[c] == 7);
    endfunction

    // ---------------- checking ----------------
    int errors = 0;
    int checks = 0;
    string cur_req = "R10";
    bit done_flag = 0;

    task automatic check(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done_flag) begin
            check(cur_req, "follow/active-low", out_follow, ~model_active(0));
            check(cur_req, "fixed/active-high", out_fixed, model_active(1));
        end
    end

    task automatic wait_ticks(int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic press_both(bit v);
        btn_a_n = ~v; btn_b_n = ~v;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done_flag) begin
            done_flag = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: inactive levels while held in reset
        check("R10", "reset level follow", out_follow, 1'b1);
        check("R10", "reset level fixed", out_fixed, 1'b0);
        rst_n = 1'b1;
        cur_req = "R11";
        supply_ok = 1'b1;
        wait_ticks(2);

        // R2: interrupted presses never reach the delay
        cur_req = "R2";
        press_both(1); wait_ticks(5);
        btn_a_n = 1'b1; wait_ticks(1);
        btn_a_n = 1'b0; wait_ticks(6);
        btn_b_n = 1'b1; wait_ticks(2);
        check("R2", "no reset follow", out_follow, 1'b1);
        check("R2", "no reset fixed", out_fixed, 1'b0);
        press_both(0); wait_ticks(2);

        // R1/R3/R5: long hold, then release
        cur_req = "R1";
        press_both(1); wait_ticks(10);
        check("R1", "asserted follow", out_follow, 1'b0);
        cur_req = "R5";
        wait_ticks(8);
        check("R5", "fixed pulse over while held", out_fixed, 1'b0);
        wait_ticks(4);
        check("R3", "still held follow", out_follow, 1'b0);
        cur_req = "R3";
        btn_b_n = 1'b1; wait_ticks(2);
        check("R3", "released follow", out_follow, 1'b1);
        press_both(0); wait_ticks(2);

        // R4: release during fixed pulse
        cur_req = "R4";
        press_both(1); wait_ticks(9);
        btn_a_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R4", "pulse continues after release", out_fixed, 1'b1);
        press_both(0); wait_ticks(PULSE + 2);
        check("R4", "pulse ended", out_fixed, 1'b0);

        // R6: supply drop mid-reset, presses ignored while low
        cur_req = "R6";
        press_both(1); wait_ticks(10);
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        check("R6", "follow off", out_follow, 1'b1);
        check("R6", "fixed off", out_fixed, 1'b0);
        wait_ticks(12);
        ovp_a = 1'b1; wait_ticks(10); ovp_a = 1'b0;
        press_both(0);
        supply_ok = 1'b1; wait_ticks(2);

        // R7: short flag rejected, long flag enters test mode
        cur_req = "R7";
        ovp_a = 1'b1; wait_ticks(3); ovp_a = 1'b0; wait_ticks(3);
        check("R7", "short flag no feedback", out_follow, 1'b1);
        ovp_a = 1'b1; wait_ticks(8);
        check("R7", "feedback follow", out_follow, 1'b0);
        wait_ticks(3);
        ovp_a = 1'b0; wait_ticks(PULSE + 2);

        // R8: shortened delay in test mode
        cur_req = "R8";
        press_both(1); wait_ticks(5);
        check("R8", "short delay follow", out_follow, 1'b0);
        press_both(0); wait_ticks(PULSE + 3);
        // R9: test mode persists across presses; flag ignored
        cur_req = "R9";
        ovp_a = 1'b1; wait_ticks(2);
        press_both(1); wait_ticks(5); press_both(0);
        ovp_a = 1'b0; wait_ticks(PULSE + 3);
        // R9: supply cycle clears test mode
        supply_ok = 1'b0; wait_ticks(2); supply_ok = 1'b1; wait_ticks(2);
        press_both(1); wait_ticks(5);
        check("R9", "normal delay restored", out_follow, 1'b1);
        wait_ticks(5);
        check("R9", "normal delay reached", out_follow, 1'b0);
        press_both(0); wait_ticks(PULSE + 3);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule